// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block runs the digital side of a 4-bit successive-approximation analog-to-digital converter. A start request launches a conversion. The block then drives a trial code to an external resistor-string DAC, whose output voltage rises with the code. For every bit it steps a clocked, auto-zeroing comparator through an input-zeroing phase and then an evaluate phase. After the comparator's own output flip-flop has captured its decision, the block reads that decision. A decision meaning "estimate above input" clears the bit on trial; any other decision keeps it. The search runs from the most significant bit down, one comparison per bit, and ends with the final code held beside a ready flag.

The phase strobes never overlap, and an idle gap always separates them. The comparator's hold-off times are parameters: the zeroing length, the evaluate length and the gap. Each trial therefore lasts `1 + ZERO_CYC + EVAL_CYC + 2*GAP_CYC` cycles: one setup cycle, the two phases and the two gaps.

Top module: `sar_ctrl`

## Requirements
- R1: While `rst_ni` is low (asynchronous), `rdy_o` is 1, `code_o` is 0 and both phase strobes are 0.
- R2: A `start_i` sampled high while `rdy_o` is 1 is accepted. At the next edge `rdy_o` drops to 0 and `code_o` becomes 4'b1000.
- R3: `zero_ph_o` and `eval_ph_o` are never high in the same cycle. Every rise of either strobe comes after at least one cycle in which both strobes were low.
- R4: Each conversion holds exactly 4 trials. Each trial has one `zero_ph_o` pulse of ZERO_CYC (default 2) cycles, followed by one `eval_ph_o` pulse of EVAL_CYC (default 2) cycles.
- R5: In trial t (t = 0 for the MSB), when `zero_ph_o` rises, bit 3-t of `code_o` is 1 and all lower bits are 0. `code_o` stays unchanged while either strobe is high.
- R6: The bit on trial is cleared when `cmp_gt_i` = 1 and kept when `cmp_gt_i` = 0. With a comparator that returns (code > level), the final code equals the level for every level from 0 to 15.
- R7: `rdy_o` returns to 1 with the final code exactly 4*(1+ZERO_CYC+EVAL_CYC+2*GAP_CYC) cycles after the accepting edge. With the defaults this is 28 cycles.
- R8: While `rdy_o` is 1 and no start is sampled, `rdy_o` and `code_o` hold their values.
- R9: A `start_i` pulse during a conversion is ignored. Neither the result nor the completion cycle changes.
- R10: `cmp_gt_i` is sampled only at the edge that ends the gap after the evaluate phase. Its value in the cycles where a strobe is high has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request |
| cmp_gt_i | input | 1 | Latched comparator decision: 1 means the estimate is above the input |
| code_o | output | 4 | Trial code to the DAC; holds the result when ready |
| zero_ph_o | output | 1 | Comparator input-zeroing phase strobe |
| eval_ph_o | output | 1 | Comparator evaluate phase strobe |
| rdy_o | output | 1 | Result valid; controller idle |

## Verification
The bench sweeps all sixteen input levels against a comparator model that latches (code > level) while the evaluate strobe is high. This tells apart a correct keep/clear rule, wrong bit order and off-by-one search. A second pass corrupts the comparator line whenever a strobe is high; only a controller that samples too early shows a wrong result there. Further runs inject a start pulse mid-conversion and a reset mid-conversion, which separate a true ignore from a restart or a lost reset. Strobe widths, gaps, trial counts and completion latency are measured for every conversion.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_ZERO,
    PH_GAP1,
    PH_EVAL,
    PH_GAP2
  } phase_e;
endpackage

// File: rtl/sar_phase_seq.sv
module sar_phase_seq
  import sar_pkg::*;
#(
  parameter int ZERO_CYC = 2,
  parameter int EVAL_CYC = 2,
  parameter int GAP_CYC  = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic last_i,
  output logic done_o,
  output logic idle_o,
  output logic zero_ph_o,
  output logic eval_ph_o
);
  localparam int MAXC = (ZERO_CYC > EVAL_CYC) ?
                        ((ZERO_CYC > GAP_CYC) ? ZERO_CYC : GAP_CYC) :
                        ((EVAL_CYC > GAP_CYC) ? EVAL_CYC : GAP_CYC);
  localparam int CW = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] ZERO_LD = CW'(ZERO_CYC - 1);
  localparam logic [CW-1:0] EVAL_LD = CW'(EVAL_CYC - 1);
  localparam logic [CW-1:0] GAP_LD  = CW'(GAP_CYC - 1);

  phase_e        phase_q;
  logic [CW-1:0] cnt_q;
  logic          cnt_end;

  assign cnt_end = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE:  if (start_i) begin phase_q <= PH_SETUP; cnt_q <= '0; end
        PH_SETUP: begin phase_q <= PH_ZERO; cnt_q <= ZERO_LD; end
        PH_ZERO:  if (cnt_end) begin phase_q <= PH_GAP1; cnt_q <= GAP_LD; end
                  else cnt_q <= cnt_q - 1'b1;
        PH_GAP1:  if (cnt_end) begin phase_q <= PH_EVAL; cnt_q <= EVAL_LD; end
                  else cnt_q <= cnt_q - 1'b1;
        PH_EVAL:  if (cnt_end) begin phase_q <= PH_GAP2; cnt_q <= GAP_LD; end
                  else cnt_q <= cnt_q - 1'b1;
        PH_GAP2:  if (cnt_end) begin
                    phase_q <= last_i ? PH_IDLE : PH_SETUP;
                    cnt_q   <= '0;
                  end else cnt_q <= cnt_q - 1'b1;
        default:  phase_q <= PH_IDLE;
      endcase
    end
  end

  // decision is read only once the comparator flip-flop has captured it
  assign done_o    = (phase_q == PH_GAP2) && cnt_end;
  assign idle_o    = (phase_q == PH_IDLE);
  assign zero_ph_o = (phase_q == PH_ZERO);
  assign eval_ph_o = (phase_q == PH_EVAL);

  a_r3_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(zero_ph_o && eval_ph_o));
  a_r3_gap_after_eval: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(eval_ph_o) |-> !zero_ph_o);
  a_r3_gap_after_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(zero_ph_o) |-> !eval_ph_o);
endmodule

// File: rtl/sar_reg.sv
module sar_reg #(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             resolve_i,
  input  logic             gt_i,
  output logic [WIDTH-1:0] code_o,
  output logic             last_o
);
  localparam logic [WIDTH-1:0] MSB = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] code_q, sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      sel_q  <= '0;
    end else if (load_i) begin
      code_q <= MSB;
      sel_q  <= MSB;
    end else if (resolve_i) begin
      code_q <= (gt_i ? (code_q & ~sel_q) : code_q) | (sel_q >> 1);
      sel_q  <= sel_q >> 1;
    end
  end

  assign code_o = code_q;
  assign last_o = sel_q[0];

  a_r6_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resolve_i && !load_i && !gt_i) |=> ((code_o & $past(sel_q)) != '0));
  a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resolve_i && !load_i && gt_i) |=> ((code_o & $past(sel_q)) == '0));
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
  parameter int WIDTH    = 4,
  parameter int ZERO_CYC = 2,
  parameter int EVAL_CYC = 2,
  parameter int GAP_CYC  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cmp_gt_i,
  output logic [WIDTH-1:0] code_o,
  output logic             zero_ph_o,
  output logic             eval_ph_o,
  output logic             rdy_o
);
  localparam logic [WIDTH-1:0] MSB = {1'b1, {(WIDTH-1){1'b0}}};

  logic rdy_q, accept, done, idle, last;

  assign accept = start_i && rdy_q && idle;

  sar_phase_seq #(
    .ZERO_CYC(ZERO_CYC),
    .EVAL_CYC(EVAL_CYC),
    .GAP_CYC (GAP_CYC)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (accept),
    .last_i   (last),
    .done_o   (done),
    .idle_o   (idle),
    .zero_ph_o(zero_ph_o),
    .eval_ph_o(eval_ph_o)
  );

  sar_reg #(.WIDTH(WIDTH)) u_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (accept),
    .resolve_i(done),
    .gt_i     (cmp_gt_i),
    .code_o   (code_o),
    .last_o   (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          rdy_q <= 1'b1;
    else if (accept)      rdy_q <= 1'b0;
    else if (done && last) rdy_q <= 1'b1;
  end

  assign rdy_o = rdy_q;

  a_r2_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && rdy_o) |=> (!rdy_o && code_o == MSB));
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_o && !start_i) |=> (rdy_o && $stable(code_o)));
  a_r5_code_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_ph_o || eval_ph_o) |-> $stable(code_o));
  a_r4_no_phase_when_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |-> !(zero_ph_o || eval_ph_o));
endmodule

// File: tb/sar_ctrl_bench.sv
module sar_ctrl_bench;
  localparam int ZC = 2, EC = 2, GC = 1;
  localparam int TRIAL = 1 + ZC + EC + 2 * GC;
  localparam int LAT = 4 * TRIAL;

  typedef struct { int level; int start_cyc; } exp_t;

  logic       clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic       cmp_ff = 1'b0, noise = 1'b0, cmp_in;
  logic [3:0] code;
  logic       zph, eph, rdy;
  int         level = 0, cyc = 0, errors = 0, checks = 0;
  bit         finished = 0;
  exp_t       q[$];

  always #5 clk = ~clk;

  sar_ctrl #(.WIDTH(4), .ZERO_CYC(ZC), .EVAL_CYC(EC), .GAP_CYC(GC)) u_sar_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmp_gt_i(cmp_in),
    .code_o(code), .zero_ph_o(zph), .eval_ph_o(eph), .rdy_o(rdy)
  );

  // comparator model: flip-flop captures (code > level) during evaluate
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (eph) cmp_ff <= (code > 4'(level));
  end
  assign cmp_in = cmp_ff ^ (noise & (zph | eph));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor
  logic [3:0] held;
  int  trials = 0, zlen = 0, elen = 0, idle_run = 0;
  bit  pz = 0, pe = 0, pr = 1, overlap = 0, moved = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      trials = 0; zlen = 0; elen = 0; idle_run = 0;
      pz = 0; pe = 0; pr = 1; overlap = 0; moved = 0;
      q.delete();
    end else begin
      if (zph && eph) overlap = 1;
      if ((zph && !pz) || (eph && !pe))
        chk(idle_run >= GC, "R3 gap", idle_run, GC);
      if (zph && !pz) begin
        int k;
        trials++;
        k = 4 - trials;
        held = code;
        if (k >= 0)
          chk(code[k] == 1'b1 && (int'(code) & ((1 << k) - 1)) == 0,
              "R5 trial pattern", code, 1 << k);
      end
      if ((zph || eph) && code != held) moved = 1;
      if (zph) zlen++;
      if (eph) elen++;
      if (!zph && pz) begin chk(zlen == ZC, "R4 zero width", zlen, ZC); zlen = 0; end
      if (!eph && pe) begin chk(elen == EC, "R4 eval width", elen, EC); elen = 0; end
      idle_run = (zph || eph) ? 0 : idle_run + 1;
      if (rdy && !pr) begin
        if (q.size() == 0) chk(0, "R9 unexpected completion", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(code == 4'(e.level), "R6 result", code, e.level);
          chk(cyc - e.start_cyc == LAT, "R7 latency", cyc - e.start_cyc, LAT);
        end
        chk(trials == 4, "R4 trial count", trials, 4);
        chk(!overlap, "R3 overlap", overlap, 0);
        chk(!moved, "R5 code stable", moved, 0);
        trials = 0; overlap = 0; moved = 0;
      end
      pz = zph; pe = eph; pr = rdy;
    end
  end

  task automatic convert(input int lvl, input bit nz, input bit intrude);
    exp_t e;
    @(negedge clk);
    level = lvl; noise = nz;
    e.level = lvl; e.start_cyc = cyc + 1;
    q.push_back(e);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!rdy && code == 4'b1000, "R2 accept", {rdy, code}, 8);
    if (intrude) begin
      repeat (9) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!rdy) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(rdy && code == 4'(lvl), "R8 hold", {rdy, code}, 16 + lvl);
    noise = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(rdy && code == 0 && !zph && !eph, "R1 reset", {rdy, code, zph, eph}, 64);
    rst_n = 1'b1;
    for (int l = 0; l < 16; l++) convert(l, 1'b0, 1'b0);
    for (int l = 0; l < 16; l += 5) convert(l, 1'b1, 1'b0);   // R10 noise on strobes
    convert(9, 1'b0, 1'b1);                                  // R9 start while busy
    convert(6, 1'b1, 1'b1);
    // reset mid-conversion
    @(negedge clk); level = 3; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(rdy && code == 0 && !zph && !eph, "R1 async reset", {rdy, code, zph, eph}, 64);
    @(negedge clk); rst_n = 1'b1;
    convert(12, 1'b0, 1'b0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule